// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block watches the command pins of a two-bank synchronous DRAM without driving anything back. On every rising clock edge it samples clock enable, chip select, the row, column and write strobes, the bank select bit and the auto-precharge address bit. It turns them into a command code and keeps a model of both banks. For each bank it holds the state (idle, open, or closing itself after an auto-precharge access) and clock-counted timers. Any command that breaks an ordering or spacing rule raises a sticky error flag with a code that names the rule.

The monitor sits beside a memory controller in simulation or silicon debug. Host logic reads the decoded command and the bank states as a live trace, and watches the error flag. The first violation is held with its code until the clear input is pulsed. Spacings are parameters counted in clock cycles: activate to column, precharge to activate, mode-set recovery, column to column, and the length of an auto-precharge burst.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is asserted and after its release, the monitor reports command code 0, both banks idle (state 0), error flag low and error code 0.
- R2: A sampled cycle is decoded into command codes from the strobes in the order row, column, write: 000 mode set = 1, 001 refresh = 2 with clock enable high or self-refresh entry = 3 with clock enable low, 011 activate = 4, 101 read = 5, 100 write = 6, 110 burst stop = 7, 010 precharge = 8, 111 no-op = 0. With chip select high the cycle is a no-op (0) and has no effect. The code is visible after the sampling edge.
- R3: If clock enable was low at the previous edge, the cycle is frozen. The command code shows 9 and bank state is unchanged. Any command other than a no-op in a frozen cycle raises error 1.
- R4: Mode set, refresh and self-refresh entry while either bank is not idle raise error 3.
- R5: Any command other than a no-op fewer than T_MRD cycles after a mode set raises error 2.
- R6: A read or write to an idle bank raises error 4.
- R7: A read or write with the auto-precharge bit high puts the bank in state 2. The bank returns to idle on the AP_CYCLES-th edge after that command. A read or write to a bank in state 2 raises error 5.
- R8: An activate to a bank that is not idle raises error 6; a legal activate puts the bank in state 1.
- R9: A read or write fewer than T_RCD cycles after the activate of its bank raises error 7.
- R10: An activate fewer than T_RP cycles after a precharge of that bank raises error 8.
- R11: A read or write fewer than T_CCD cycles after the previous legal read or write raises error 9.
- R12: A precharge with the auto-precharge bit high idles both banks. With the bit low it idles only the selected bank.
- R13: Only the first error is latched: flag high, code held, later errors ignored until the clear input returns flag and code to 0. A command that raises an error leaves bank state and timers unchanged. When several rules fail, the lowest code applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all pins sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| bankAddr | input | 1 | Bank select bit |
| apBit | input | 1 | Auto-precharge / all-banks address bit |
| errClr | input | 1 | Clears the latched error at the next edge |
| cmdCode | output | 4 | Last sampled command code |
| bank0State | output | 2 | State of bank 0 (0 idle, 1 open, 2 auto-precharge) |
| bank1State | output | 2 | State of bank 1 |
| errFlag | output | 1 | Sticky error flag |
| errCode | output | 4 | Code of the first latched error |

## Verification
A bank model that drifts from the real sequence shows up at the bank state outputs right after the edge that caused it. It also shows up one command later, as a false error or a missing one, on a column or activate to that bank. A timer that is off by one is found by commands placed exactly one cycle short of each spacing and exactly on it. A broken latch shows as an error code that changes after a second violation, or that survives a clear. The directed scenarios look at the ports after every edge, so a fault is caught within one or two cycles of the stimulus that exposes it.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  localparam int NUM_BANKS = 2;

  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_MRS    = 4'd1,
    CMD_REF    = 4'd2,
    CMD_SREF   = 4'd3,
    CMD_ACT    = 4'd4,
    CMD_RD     = 4'd5,
    CMD_WR     = 4'd6,
    CMD_BST    = 4'd7,
    CMD_PRE    = 4'd8,
    CMD_FROZEN = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_ACTIVE  = 2'd1,
    BK_AUTOPRE = 2'd2
  } bank_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_CKE      = 4'd1,
    ERR_MRD      = 4'd2,
    ERR_BUSY     = 4'd3,
    ERR_COL_IDLE = 4'd4,
    ERR_COL_AP   = 4'd5,
    ERR_ACT_OPEN = 4'd6,
    ERR_RCD      = 4'd7,
    ERR_RP       = 4'd8,
    ERR_CCD      = 4'd9
  } err_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] act;
    logic [NUM_BANKS-1:0] pre;
    logic [NUM_BANKS-1:0] col;
    logic                 colAp;
    logic                 mrs;
  } strobe_t;

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mon_track.sv
module sdram_mon_track
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_CCD     = 1,
  parameter int AP_CYCLES = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  output bank_e                bankState [NUM_BANKS],
  output logic [NUM_BANKS-1:0] rcdOk,
  output logic [NUM_BANKS-1:0] rpOk,
  output logic                 ccdOk,
  output logic                 mrdOk
);

  localparam int MAXT = maxOf(maxOf(T_RCD, T_RP), maxOf(T_MRD, T_CCD));
  localparam int CW   = $clog2(MAXT + 1);
  localparam int AW   = $clog2(AP_CYCLES + 1);
  localparam logic [CW-1:0] SAT = CW'(MAXT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_e         st;
    logic [CW-1:0] rcdCnt;
    logic [CW-1:0] rpCnt;
    logic [AW-1:0] apCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st     <= BK_IDLE;
        rcdCnt <= SAT;
        rpCnt  <= SAT;
        apCnt  <= '0;
      end else begin
        if (rcdCnt != SAT) rcdCnt <= rcdCnt + 1'b1;
        if (rpCnt != SAT)  rpCnt  <= rpCnt + 1'b1;
        if (stb.act[b]) begin
          st     <= BK_ACTIVE;
          rcdCnt <= CW'(1);
        end else if (stb.pre[b]) begin
          st    <= BK_IDLE;
          rpCnt <= CW'(1);
          apCnt <= '0;
        end else if (stb.col[b] && stb.colAp) begin
          st    <= BK_AUTOPRE;
          apCnt <= AW'(AP_CYCLES);
        end else if (st == BK_AUTOPRE) begin
          if (apCnt == AW'(1)) st <= BK_IDLE;
          apCnt <= apCnt - 1'b1;
        end
      end
    end

    assign bankState[b] = st;
    assign rcdOk[b]     = (rcdCnt >= CW'(T_RCD));
    assign rpOk[b]      = (rpCnt >= CW'(T_RP));

    // R7: a self-closing bank always has cycles left to count
    a_r7_ap_live: assert property (@(posedge clk) disable iff (!rstN)
      (st == BK_AUTOPRE) |-> (apCnt != '0));
    // R6/R7: column strobes reach only an open bank
    a_r6_col_open: assert property (@(posedge clk) disable iff (!rstN)
      stb.col[b] |-> (st == BK_ACTIVE));
    // R10: activate strobes respect the precharge spacing
    a_r10_act_spaced: assert property (@(posedge clk) disable iff (!rstN)
      stb.act[b] |-> (st == BK_IDLE && rpCnt >= CW'(T_RP)));
  end

  logic [CW-1:0] ccdCnt;
  logic [CW-1:0] mrdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ccdCnt <= SAT;
      mrdCnt <= SAT;
    end else begin
      if (|stb.col)           ccdCnt <= CW'(1);
      else if (ccdCnt != SAT) ccdCnt <= ccdCnt + 1'b1;
      if (stb.mrs)            mrdCnt <= CW'(1);
      else if (mrdCnt != SAT) mrdCnt <= mrdCnt + 1'b1;
    end
  end

  assign ccdOk = (ccdCnt >= CW'(T_CCD));
  assign mrdOk = (mrdCnt >= CW'(T_MRD));

  // R12: precharge of every bank leaves both idle
  a_r12_all_idle: assert property (@(posedge clk) disable iff (!rstN)
    (&stb.pre) |=> (bankState[0] == BK_IDLE && bankState[1] == BK_IDLE));

endmodule

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 bankAddr,
  input  logic                 apBit,
  input  logic                 errClr,
  input  bank_e                bankState [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] rcdOk,
  input  logic [NUM_BANKS-1:0] rpOk,
  input  logic                 ccdOk,
  input  logic                 mrdOk,
  output strobe_t              stb,
  output logic [3:0]           cmdCode,
  output logic                 errFlag,
  output logic [3:0]           errCode
);

  logic  ckePrev;
  cmd_e  rawCmd;
  cmd_e  curCmd;
  err_e  hitErr;
  cmd_e  cmdQ;
  err_e  errQ;
  logic  anyBusy;
  bank_e selState;

  always_comb begin
    rawCmd = CMD_NOP;
    if (!csN) begin
      unique case ({rasN, casN, weN})
        3'b000:  rawCmd = CMD_MRS;
        3'b001:  rawCmd = cke ? CMD_REF : CMD_SREF;
        3'b011:  rawCmd = CMD_ACT;
        3'b101:  rawCmd = CMD_RD;
        3'b100:  rawCmd = CMD_WR;
        3'b110:  rawCmd = CMD_BST;
        3'b010:  rawCmd = CMD_PRE;
        default: rawCmd = CMD_NOP;
      endcase
    end
  end

  assign curCmd   = ckePrev ? rawCmd : CMD_FROZEN;
  assign selState = bankState[bankAddr];
  assign anyBusy  = (bankState[0] != BK_IDLE) || (bankState[1] != BK_IDLE);

  always_comb begin
    hitErr = ERR_NONE;
    if (!ckePrev) begin
      if (rawCmd != CMD_NOP) hitErr = ERR_CKE;
    end else if (rawCmd != CMD_NOP && !mrdOk) begin
      hitErr = ERR_MRD;
    end else begin
      case (rawCmd)
        CMD_MRS, CMD_REF, CMD_SREF: if (anyBusy) hitErr = ERR_BUSY;
        CMD_RD, CMD_WR: begin
          if (selState == BK_IDLE)         hitErr = ERR_COL_IDLE;
          else if (selState == BK_AUTOPRE) hitErr = ERR_COL_AP;
          else if (!rcdOk[bankAddr])       hitErr = ERR_RCD;
          else if (!ccdOk)                 hitErr = ERR_CCD;
        end
        CMD_ACT: begin
          if (selState != BK_IDLE)   hitErr = ERR_ACT_OPEN;
          else if (!rpOk[bankAddr])  hitErr = ERR_RP;
        end
        default: hitErr = ERR_NONE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    if (ckePrev && hitErr == ERR_NONE) begin
      case (rawCmd)
        CMD_ACT: stb.act[bankAddr] = 1'b1;
        CMD_PRE: begin
          if (apBit) stb.pre = '1;
          else       stb.pre[bankAddr] = 1'b1;
        end
        CMD_RD, CMD_WR: begin
          stb.col[bankAddr] = 1'b1;
          stb.colAp         = apBit;
        end
        CMD_MRS: stb.mrs = 1'b1;
        default: stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev <= 1'b1;
      cmdQ    <= CMD_NOP;
      errFlag <= 1'b0;
      errQ    <= ERR_NONE;
    end else begin
      ckePrev <= cke;
      cmdQ    <= curCmd;
      if (errClr) begin
        errFlag <= 1'b0;
        errQ    <= ERR_NONE;
      end else if (!errFlag && hitErr != ERR_NONE) begin
        errFlag <= 1'b1;
        errQ    <= hitErr;
      end
    end
  end

  assign cmdCode = cmdQ;
  assign errCode = errQ;

  // R3: a frozen cycle never moves the bank model
  a_r3_frozen_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ckePrev |-> (stb == '0));
  // R13: the latched error is held until cleared
  a_r13_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> (errFlag && $stable(errCode)));
  // R13: a raised flag always carries a code
  a_r13_code_set: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (errCode != 4'd0));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_CCD     = 1,
  parameter int AP_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       bankAddr,
  input  logic       apBit,
  input  logic       errClr,
  output logic [3:0] cmdCode,
  output logic [1:0] bank0State,
  output logic [1:0] bank1State,
  output logic       errFlag,
  output logic [3:0] errCode
);

  strobe_t              stb;
  bank_e                bankState [NUM_BANKS];
  logic [NUM_BANKS-1:0] rcdOk;
  logic [NUM_BANKS-1:0] rpOk;
  logic                 ccdOk;
  logic                 mrdOk;

  sdram_mon_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .bankAddr(bankAddr), .apBit(apBit),
    .errClr(errClr), .bankState(bankState), .rcdOk(rcdOk), .rpOk(rpOk),
    .ccdOk(ccdOk), .mrdOk(mrdOk), .stb(stb), .cmdCode(cmdCode),
    .errFlag(errFlag), .errCode(errCode)
  );

  sdram_mon_track #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_MRD(T_MRD), .T_CCD(T_CCD),
    .AP_CYCLES(AP_CYCLES)
  ) track_i (
    .clk(clk), .rstN(rstN), .stb(stb), .bankState(bankState),
    .rcdOk(rcdOk), .rpOk(rpOk), .ccdOk(ccdOk), .mrdOk(mrdOk)
  );

  assign bank0State = bankState[0];
  assign bank1State = bankState[1];

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;

  localparam int AP = 6;

  localparam logic [3:0] C_NOP = 4'd0, C_MRS = 4'd1, C_REF = 4'd2, C_SREF = 4'd3,
                         C_ACT = 4'd4, C_RD = 4'd5, C_WR = 4'd6, C_BST = 4'd7,
                         C_PRE = 4'd8, C_FRZ = 4'd9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic bankAddr = 1'b0, apBit = 1'b0, errClr = 1'b0;
  logic [3:0] cmdCode;
  logic [1:0] bank0State, bank1State;
  logic       errFlag;
  logic [3:0] errCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(
    .T_RCD(3), .T_RP(3), .T_MRD(2), .T_CCD(2), .AP_CYCLES(AP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .apBit(apBit), .errClr(errClr),
    .cmdCode(cmdCode), .bank0State(bank0State), .bank1State(bank1State),
    .errFlag(errFlag), .errCode(errCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one command across one rising edge, then sample after it
  task automatic cyc(input logic [3:0] c, input logic b = 1'b0, input logic a = 1'b0,
                     input logic k = 1'b1, input logic cs = 1'b0, input logic clr = 1'b0);
    @(negedge clk);
    cke = k; csN = cs; bankAddr = b; apBit = a; errClr = clr;
    case (c)
      C_MRS:         {rasN, casN, weN} = 3'b000;
      C_REF, C_SREF: {rasN, casN, weN} = 3'b001;
      C_ACT:         {rasN, casN, weN} = 3'b011;
      C_RD:          {rasN, casN, weN} = 3'b101;
      C_WR:          {rasN, casN, weN} = 3'b100;
      C_BST:         {rasN, casN, weN} = 3'b110;
      C_PRE:         {rasN, casN, weN} = 3'b010;
      default:       {rasN, casN, weN} = 3'b111;
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cke = 1'b1; csN = 1'b1; {rasN, casN, weN} = 3'b111;
    bankAddr = 1'b0; apBit = 1'b0; errClr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    doReset();
    check("R1 cmdCode", cmdCode, 0);
    check("R1 bank0", bank0State, 0);
    check("R1 bank1", bank1State, 0);
    check("R1 errFlag", errFlag, 0);
    check("R1 errCode", errCode, 0);
    cyc(C_NOP);
    check("R1 cmd after release", cmdCode, 0);
  endtask

  task automatic tDecode();
    doReset();
    cyc(C_MRS, 0, 0, 1, 1);
    check("R2 deselect code", cmdCode, C_NOP);
    cyc(C_ACT, 0);
    check("R2 deselect no effect", errCode, 0);
    check("R2 act code", cmdCode, C_ACT);
    cyc(C_BST);
    check("R2 bst code", cmdCode, C_BST);
    cyc(C_PRE, 0);
    check("R2 pre code", cmdCode, C_PRE);
    cyc(C_NOP);
    cyc(C_NOP);
    cyc(C_SREF, 0, 0, 0);
    check("R2 self refresh code", cmdCode, C_SREF);
    check("R4 sref idle legal", errCode, 0);
  endtask

  task automatic tCke();
    doReset();
    cyc(C_NOP, 0, 0, 0);
    check("R3 cke drop edge", cmdCode, C_NOP);
    cyc(C_NOP, 0, 0, 0);
    check("R3 frozen code", cmdCode, C_FRZ);
    cyc(C_NOP, 0, 0, 1);
    check("R3 frozen exit", cmdCode, C_FRZ);
    check("R3 nop frozen legal", errCode, 0);
    cyc(C_ACT, 0);
    check("R3 act after wake", bank0State, 1);
    doReset();
    cyc(C_NOP, 0, 0, 0);
    cyc(C_ACT, 0, 0, 1);
    check("R3 cmd in frozen code", cmdCode, C_FRZ);
    check("R3 cmd in frozen err", errCode, 1);
    check("R3 frozen no state", bank0State, 0);
  endtask

  task automatic tMrs();
    doReset();
    cyc(C_MRS);
    check("R2 mrs code", cmdCode, C_MRS);
    check("R4 mrs idle legal", errCode, 0);
    cyc(C_ACT, 0);
    check("R5 mrd gap err", errCode, 2);
    check("R13 illegal act no state", bank0State, 0);
    doReset();
    cyc(C_MRS);
    cyc(C_NOP);
    cyc(C_ACT, 0);
    check("R5 mrd met", errCode, 0);
    check("R8 act opens", bank0State, 1);
    cyc(C_REF);
    check("R2 ref code", cmdCode, C_REF);
    check("R4 ref busy", errCode, 3);
  endtask

  task automatic tActRead();
    doReset();
    cyc(C_ACT, 0);
    cyc(C_NOP);
    cyc(C_NOP);
    cyc(C_RD, 0);
    check("R9 rcd met code", cmdCode, C_RD);
    check("R9 rcd met err", errCode, 0);
    cyc(C_WR, 0);
    check("R11 ccd err", errCode, 9);
    check("R13 flag", errFlag, 1);
    cyc(C_RD, 1);
    check("R13 first held", errCode, 9);
    cyc(C_NOP, 0, 0, 1, 0, 1);
    check("R13 clear flag", errFlag, 0);
    check("R13 clear code", errCode, 0);
    cyc(C_WR, 0);
    check("R11 ccd met", errCode, 0);
    check("R2 wr code", cmdCode, C_WR);
  endtask

  task automatic tRcd();
    doReset();
    cyc(C_ACT, 1);
    check("R8 bank1 open", bank1State, 1);
    cyc(C_RD, 1);
    check("R9 rcd err", errCode, 7);
  endtask

  task automatic tIdleCol();
    doReset();
    cyc(C_WR, 0);
    check("R6 col idle err", errCode, 4);
    check("R6 bank stays idle", bank0State, 0);
  endtask

  task automatic tActBusy();
    doReset();
    cyc(C_ACT, 0);
    cyc(C_ACT, 0);
    check("R8 act open err", errCode, 6);
  endtask

  task automatic tRp();
    doReset();
    cyc(C_ACT, 0);
    cyc(C_NOP);
    cyc(C_PRE, 0, 0);
    check("R12 single pre bank0", bank0State, 0);
    cyc(C_ACT, 1);
    check("R10 other bank legal", errCode, 0);
    check("R10 other bank open", bank1State, 1);
    cyc(C_ACT, 0);
    check("R10 rp err", errCode, 8);
    check("R13 rp no state", bank0State, 0);
  endtask

  task automatic tPreAll();
    doReset();
    cyc(C_ACT, 0);
    cyc(C_ACT, 1);
    cyc(C_PRE, 0, 0);
    check("R12 pre one keeps other", bank1State, 1);
    cyc(C_PRE, 0, 1);
    check("R12 all bank0", bank0State, 0);
    check("R12 all bank1", bank1State, 0);
    check("R12 no err", errCode, 0);
  endtask

  task automatic tAutoPre();
    doReset();
    cyc(C_ACT, 0);
    cyc(C_NOP);
    cyc(C_NOP);
    cyc(C_RD, 0, 1);
    check("R7 ap state", bank0State, 2);
    cyc(C_RD, 0);
    check("R7 col to ap err", errCode, 5);
    for (int i = 0; i < AP - 2; i++) cyc(C_NOP);
    check("R7 ap still busy", bank0State, 2);
    cyc(C_NOP);
    check("R7 ap done idle", bank0State, 0);
  endtask

  initial begin
    tReset();
    tDecode();
    tCke();
    tMrs();
    tActRead();
    tRcd();
    tIdleCol();
    tActBusy();
    tRp();
    tPreAll();
    tAutoPre();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule